// File: doc/BRIEF.md
# Address Table Clear and Age-Out Engine

This block owns the write port of a small address table and runs two maintenance jobs that software starts from a two-bit control register. A wipe job zeroes every entry over a fixed window of clock cycles. An age-out sweep walks the table one entry at a time. It frees each ageable entry whose touch flag is clear. It clears the touch flag on each ageable entry that was touched, so that entry is freed on the next sweep unless traffic touches it again. Static entries are left as they are.

A packet-lookup port shares the table and has strict priority. It can read any entry at any time. It can write any entry except while a wipe is running. The sweep stops in its current step for every cycle in which a lookup is asserted, so traffic makes a sweep take longer. While a wipe runs, the control interface inserts wait states. For this reason the wipe trigger can never be read back as 1. The sweep trigger reads 1 for as long as the sweep runs and clears itself when the sweep ends.

Top module: `tbl_maint_engine`

## Requirements
- R1: After reset every table entry reads zero, `ctl_rd_data` is 0, `busy` is 0 and `ctl_ready` is 1.
- R2: A control write accepted with bit 1 set starts a wipe. `ctl_ready` is low for exactly CLR_CYCLES (64) cycles, starting with the cycle after the accepting edge. Every entry reads zero when the wipe has finished.
- R3: A control access made during a wipe completes only when `ctl_ready` returns high. Whenever `ctl_ready` is high, bit 1 of `ctl_rd_data` is 0.
- R4: The sweep writes all zeros to every entry that has the ageable flag (bit ENTRY_W-1) set and the touch flag (bit ENTRY_W-2) clear.
- R5: The sweep clears only the touch flag of an entry that has both flags set, so a second sweep with no new touch frees that entry. Entries with the ageable flag clear are not changed.
- R6: A control write accepted with value 2'b01 sets bit 0 of `ctl_rd_data` on the next cycle. With no lookups, bit 0 stays 1 for exactly 4×DEPTH cycles (64 by default) and then returns to 0.
- R7: Each cycle in which `lk_req` is high during a sweep lengthens the sweep by one cycle. A lookup write made during a sweep takes effect and is kept.
- R8: A wipe started during a sweep aborts the sweep. When the wipe ends, both control bits read 0.
- R9: A lookup write issued while a wipe is running has no effect on the table.
- R10: A control write of 2'b00 has no effect. Writing 2'b01 while a sweep is running does not restart it or change its length.
- R11: `busy` is 1 whenever a wipe or a sweep is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control write strobe, held until accepted |
| ctl_wr_data | input | 2 | Bit 1 starts a wipe, bit 0 starts a sweep |
| ctl_rd_data | output | 2 | Bit 1 shows a wipe running, bit 0 shows a sweep pending or running |
| ctl_ready | output | 1 | Low inserts wait states on control accesses |
| busy | output | 1 | A maintenance job is in progress |
| lk_req | input | 1 | Lookup request, has priority over the sweep |
| lk_we | input | 1 | Lookup writes `lk_wdata` to the entry |
| lk_idx | input | IDXW | Lookup entry index |
| lk_wdata | input | ENTRY_W | Lookup write data |
| lk_rdata | output | ENTRY_W | Entry at `lk_idx` |

## Verification
Some properties are checked on every cycle by assertions. These cover how long the stall lasts, the wipe bit never showing while the interface is ready, the sweep bit rising after an accepted start and holding through lookup pauses, both bits reading zero when a wipe ends, and `busy` covering both jobs. Other behaviour can only be shown by the bench's scenarios, which read the table back through the lookup port. These are the contents of each entry after a sweep or wipe, the exact sweep length with and without lookup pauses, aging over two sweeps, a lookup write dropped during a wipe, and a sweep aborted by a wipe.

// File: rtl/tme_pkg.sv
package tme_pkg;
  // Per-entry step of the age-out sweep
  typedef enum logic [2:0] {
    SW_IDLE,
    SW_READ,
    SW_EVAL,
    SW_WRITE,
    SW_NEXT
  } sweep_st_e;
endpackage

// File: rtl/tme_rst_sync.sv
module tme_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tme_wipe.sv
module tme_wipe #(
  parameter  int DEPTH      = 16,
  parameter  int CLR_CYCLES = 64,
  localparam int IDXW       = $clog2(DEPTH),
  localparam int CNTW       = $clog2(CLR_CYCLES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            active,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic            done
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            act_q, act_d;
  logic            cnt_en, last;

  assign last = (cnt_q == CNTW'(CLR_CYCLES - 1));

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = start | act_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign active = act_q;
  assign wr_en  = act_q && (int'(cnt_q) < DEPTH);
  assign wr_idx = cnt_q[IDXW-1:0];
  assign done   = act_q && last;
endmodule

// File: rtl/tme_sweep.sv
module tme_sweep
  import tme_pkg::*;
#(
  parameter  int DEPTH   = 16,
  parameter  int ENTRY_W = 16,
  localparam int IDXW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               hold,
  input  logic               wr_hit,
  input  logic [ENTRY_W-1:0] cur_entry,
  output logic               active,
  output logic [IDXW-1:0]    idx,
  output logic               wr_en,
  output logic [ENTRY_W-1:0] wr_data,
  output logic               done
);
  localparam int              AGE_POS  = ENTRY_W - 1;
  localparam int              TCH_POS  = ENTRY_W - 2;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

  sweep_st_e          st_q, st_d;
  logic [IDXW-1:0]    idx_q, idx_d;
  logic [ENTRY_W-1:0] ent_q, new_q, new_d;
  logic               need_q, need_d;
  logic               ent_en, new_en, last;

  assign last = (idx_q == LAST_IDX);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    ent_en = 1'b0;
    new_en = 1'b0;
    need_d = ent_q[AGE_POS];
    new_d  = ent_q;
    if (ent_q[TCH_POS]) new_d[TCH_POS] = 1'b0;
    else                new_d = '0;

    if (abort) begin
      st_d = SW_IDLE;
    end else if (st_q == SW_IDLE) begin
      if (start) begin
        st_d  = SW_READ;
        idx_d = '0;
      end
    end else if (wr_hit && (st_q == SW_EVAL || st_q == SW_WRITE)) begin
      // entry changed under the sweep: fetch it again
      st_d = SW_READ;
    end else if (!hold) begin
      case (st_q)
        SW_READ:  begin ent_en = 1'b1; st_d = SW_EVAL;  end
        SW_EVAL:  begin new_en = 1'b1; st_d = SW_WRITE; end
        SW_WRITE: st_d = SW_NEXT;
        SW_NEXT: begin
          if (last) st_d = SW_IDLE;
          else begin
            idx_d = idx_q + 1'b1;
            st_d  = SW_READ;
          end
        end
        default:  st_d = SW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      idx_q  <= '0;
      ent_q  <= '0;
      new_q  <= '0;
      need_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (ent_en) ent_q <= cur_entry;
      if (new_en) begin
        new_q  <= new_d;
        need_q <= need_d;
      end
    end
  end

  assign active  = (st_q != SW_IDLE);
  assign idx     = idx_q;
  assign wr_data = new_q;
  assign wr_en   = (st_q == SW_WRITE) && !hold && !abort && need_q;
  assign done    = (st_q == SW_NEXT) && !hold && !abort && last;
endmodule

// File: rtl/tme_store.sv
module tme_store #(
  parameter  int DEPTH   = 16,
  parameter  int ENTRY_W = 16,
  localparam int IDXW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDXW-1:0]    widx,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [IDXW-1:0]    ra_idx,
  output logic [ENTRY_W-1:0] ra_data,
  input  logic [IDXW-1:0]    rb_idx,
  output logic [ENTRY_W-1:0] rb_data
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (we && (widx == IDXW'(i))) mem_q[i] <= wdata;
    end
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];
endmodule

// File: rtl/tbl_maint_engine.sv
module tbl_maint_engine #(
  parameter  int DEPTH      = 16,
  parameter  int ENTRY_W    = 16,
  parameter  int CLR_CYCLES = 64,
  localparam int IDXW       = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_en,
  input  logic [1:0]         ctl_wr_data,
  output logic [1:0]         ctl_rd_data,
  output logic               ctl_ready,
  output logic               busy,
  input  logic               lk_req,
  input  logic               lk_we,
  input  logic [IDXW-1:0]    lk_idx,
  input  logic [ENTRY_W-1:0] lk_wdata,
  output logic [ENTRY_W-1:0] lk_rdata
);
  logic               srst_n;
  logic               wipe_active, wipe_we, wipe_done, wipe_start;
  logic [IDXW-1:0]    wipe_idx;
  logic               sw_active, sw_we, sw_done, sw_start;
  logic [IDXW-1:0]    sw_idx;
  logic [ENTRY_W-1:0] sw_wdata, sw_entry;
  logic               acc_wr, lk_we_eff, wr_hit;
  logic               age_q, age_d, age_en;
  logic               t_we;
  logic [IDXW-1:0]    t_idx;
  logic [ENTRY_W-1:0] t_data;

  tme_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(srst_n));

  assign acc_wr     = ctl_wr_en & ~wipe_active;
  assign wipe_start = acc_wr & ctl_wr_data[1];
  assign sw_start   = acc_wr & ctl_wr_data[0] & ~ctl_wr_data[1];
  assign lk_we_eff  = lk_req & lk_we & ~wipe_active;
  assign wr_hit     = lk_we_eff & (lk_idx == sw_idx);

  tme_wipe #(.DEPTH(DEPTH), .CLR_CYCLES(CLR_CYCLES)) u_wipe (
    .clk(clk), .rst_n(srst_n), .start(wipe_start), .active(wipe_active),
    .wr_en(wipe_we), .wr_idx(wipe_idx), .done(wipe_done)
  );

  tme_sweep #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_sweep (
    .clk(clk), .rst_n(srst_n), .start(sw_start), .abort(wipe_start),
    .hold(lk_req), .wr_hit(wr_hit), .cur_entry(sw_entry), .active(sw_active),
    .idx(sw_idx), .wr_en(sw_we), .wr_data(sw_wdata), .done(sw_done)
  );

  // Single write port: wipe, then lookup, then sweep
  always_comb begin
    t_we   = 1'b0;
    t_idx  = sw_idx;
    t_data = sw_wdata;
    if (wipe_we) begin
      t_we   = 1'b1;
      t_idx  = wipe_idx;
      t_data = '0;
    end else if (lk_we_eff) begin
      t_we   = 1'b1;
      t_idx  = lk_idx;
      t_data = lk_wdata;
    end else if (sw_we) begin
      t_we = 1'b1;
    end
  end

  tme_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(srst_n), .we(t_we), .widx(t_idx), .wdata(t_data),
    .ra_idx(lk_idx), .ra_data(lk_rdata), .rb_idx(sw_idx), .rb_data(sw_entry)
  );

  // Sweep trigger bit: set on an accepted start, cleared by sweep or wipe end
  always_comb begin
    age_d  = age_q;
    age_en = wipe_done | sw_start | sw_done;
    if (wipe_done)                   age_d = 1'b0;
    else if (sw_start && !sw_active) age_d = 1'b1;
    else if (sw_done)                age_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     age_q <= 1'b0;
    else if (age_en) age_q <= age_d;
  end

  assign ctl_ready   = ~wipe_active;
  assign ctl_rd_data = {wipe_active, age_q};
  assign busy        = wipe_active | sw_active;
endmodule

// File: rtl/tme_chk.sv
module tme_chk #(
  parameter int CLR_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr_en,
  input logic [1:0] ctl_wr_data,
  input logic [1:0] ctl_rd_data,
  input logic       ctl_ready,
  input logic       busy,
  input logic       lk_req
);
  int stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stall_cnt <= 0;
    else if (!ctl_ready) stall_cnt <= stall_cnt + 1;
    else                 stall_cnt <= 0;
  end

  p_wipe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_ready && ctl_wr_data[1]) |=> !ctl_ready);

  p_stall_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ready |-> (stall_cnt < CLR_CYCLES));

  p_stall_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_ready) |-> (stall_cnt == CLR_CYCLES));

  p_rd_hides_wipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_ready |-> !ctl_rd_data[1]);

  p_age_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_ready && ctl_wr_data == 2'b01) |=> ctl_rd_data[0]);

  p_pause_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && ctl_ready && ctl_rd_data[0]) |=> ctl_rd_data[0]);

  p_wipe_end_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_ready) |-> (ctl_rd_data == 2'b00));

  p_busy_cover_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_data[0] || !ctl_ready) |-> busy);
endmodule

bind tbl_maint_engine tme_chk #(.CLR_CYCLES(CLR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
  .ctl_rd_data(ctl_rd_data), .ctl_ready(ctl_ready), .busy(busy), .lk_req(lk_req)
);

// File: tb/tbl_maint_engine_bench.sv
module tbl_maint_engine_bench;
  localparam int DEPTH = 16;
  localparam int EW    = 16;
  localparam int IDXW  = 4;

  // {initial entry, entry after one sweep}; bit15 ageable, bit14 touched
  localparam logic [31:0] VEC [8] = '{
    {16'h8123, 16'h0000}, {16'hC456, 16'h8456},
    {16'h4789, 16'h4789}, {16'h0ABC, 16'h0ABC},
    {16'h9FFF, 16'h0000}, {16'hFFFF, 16'hBFFF},
    {16'h3FFF, 16'h3FFF}, {16'h8000, 16'h0000}
  };

  logic            clk, rst_n;
  logic            ctl_wr_en;
  logic [1:0]      ctl_wr_data, ctl_rd_data;
  logic            ctl_ready, busy;
  logic            lk_req, lk_we;
  logic [IDXW-1:0] lk_idx;
  logic [EW-1:0]   lk_wdata, lk_rdata;

  int n_chk = 0;
  int n_fail = 0;

  tbl_maint_engine u_tbl_maint_engine (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .ctl_ready(ctl_ready), .busy(busy),
    .lk_req(lk_req), .lk_we(lk_we), .lk_idx(lk_idx), .lk_wdata(lk_wdata),
    .lk_rdata(lk_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lk_write(input int idx, input logic [EW-1:0] d);
    lk_req = 1'b1; lk_we = 1'b1; lk_idx = IDXW'(idx); lk_wdata = d;
    @(negedge clk);
    lk_req = 1'b0; lk_we = 1'b0;
  endtask

  task automatic lk_read(input int idx, output logic [EW-1:0] d);
    lk_idx = IDXW'(idx);
    #1 d = lk_rdata;
  endtask

  task automatic ctl_write(input logic [1:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    while (!ctl_ready) @(negedge clk);
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = 2'b00;
  endtask

  task automatic wait_ready(output int waits);
    waits = 0;
    while (!ctl_ready && waits < 1000) begin waits++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [EW-1:0] rd;
    int waits, cnt;
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = 2'b00;
    lk_req = 1'b0; lk_we = 1'b0; lk_idx = '0; lk_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", 32'(ctl_rd_data), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ready", 32'(ctl_ready), 1);
    lk_read(0, rd);  chk("R1 entry0", 32'(rd), 0);
    lk_read(15, rd); chk("R1 entry15", 32'(rd), 0);
    @(negedge clk);

    // R2/R3 wipe: fill, wipe, count wait states
    for (int i = 0; i < DEPTH; i++) lk_write(i, 16'hFFFF);
    ctl_write(2'b10);
    chk("R11 busy during wipe", 32'(busy), 1);
    wait_ready(waits);
    chk("R2/R3 wait states", 32'(waits), 64);
    chk("R3 wipe bit reads 0", 32'(ctl_rd_data), 0);
    for (int i = 0; i < DEPTH; i++) begin
      lk_read(i, rd);
      chk("R2 entry zeroed", 32'(rd), 0);
    end
    @(negedge clk);

    // R4/R5/R6 vector sweep
    for (int i = 0; i < 8; i++) lk_write(i, VEC[i][31:16]);
    ctl_write(2'b01);
    cnt = 0;
    while (ctl_rd_data[0] && cnt < 1000) begin
      if (cnt == 10) chk("R11 busy during sweep", 32'(busy), 1);
      cnt++; @(negedge clk);
    end
    chk("R6 sweep length", 32'(cnt), 64);
    chk("R11 busy after sweep", 32'(busy), 0);
    for (int i = 0; i < 8; i++) begin
      lk_read(i, rd);
      chk("R4/R5 swept entry", 32'(rd), 32'(VEC[i][15:0]));
    end
    @(negedge clk);

    // R5 second sweep frees formerly touched entries
    ctl_write(2'b01);
    wait (ctl_rd_data[0] == 1'b0);
    @(negedge clk);
    lk_read(1, rd); chk("R5 second sweep frees", 32'(rd), 0);
    lk_read(5, rd); chk("R5 second sweep frees", 32'(rd), 0);
    lk_read(2, rd); chk("R5 static kept", 32'(rd), 32'h4789);
    @(negedge clk);

    // R7 lookups stretch the sweep; lookup write kept
    ctl_write(2'b01);
    cnt = 0;
    while (ctl_rd_data[0] && cnt < 1000) begin
      lk_req   = (cnt >= 5 && cnt < 15);
      lk_we    = (cnt == 5);
      lk_idx   = (cnt == 5) ? 4'd15 : 4'd3;
      lk_wdata = 16'h1234;
      cnt++; @(negedge clk);
    end
    lk_req = 1'b0; lk_we = 1'b0;
    chk("R7 stretched length", 32'(cnt), 74);
    lk_read(15, rd); chk("R7 lookup write kept", 32'(rd), 32'h1234);
    @(negedge clk);

    // R10 write of zero; retrigger during sweep
    ctl_write(2'b00);
    chk("R10 zero write bits", 32'(ctl_rd_data), 0);
    chk("R10 zero write busy", 32'(busy), 0);
    lk_read(15, rd); chk("R10 zero write table", 32'(rd), 32'h1234);
    @(negedge clk);
    ctl_write(2'b01);
    cnt = 0;
    while (ctl_rd_data[0] && cnt < 1000) begin
      ctl_wr_en = (cnt == 20); ctl_wr_data = (cnt == 20) ? 2'b01 : 2'b00;
      cnt++; @(negedge clk);
    end
    ctl_wr_en = 1'b0; ctl_wr_data = 2'b00;
    chk("R10 retrigger length", 32'(cnt), 64);

    // R8 wipe aborts sweep
    lk_write(12, 16'hC111);
    ctl_write(2'b01);
    repeat (5) @(negedge clk);
    ctl_write(2'b10);
    wait_ready(waits);
    chk("R8 bits after abort", 32'(ctl_rd_data), 0);
    chk("R8 busy after abort", 32'(busy), 0);
    lk_read(12, rd); chk("R8 entry wiped", 32'(rd), 0);
    @(negedge clk);

    // R9 lookup write during wipe dropped
    ctl_write(2'b10);
    repeat (20) @(negedge clk);
    lk_write(2, 16'h0ABC);
    wait_ready(waits);
    lk_read(2, rd); chk("R9 write dropped", 32'(rd), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule